// File: doc/BRIEF.md
# Transmit Path Safety Gate

This block sits between the transmit data input of a single-wire bus transceiver and its bus driver. It passes a low level on the transmit input through as a request to drive the bus dominant. Three independent protections can override that request and hold the bus recessive. The first is a stuck-dominant timer. The second is a thermal interlock that re-arms only after it sees a recessive input. The third is a supply-monitor hysteresis latch driven by two comparator flags. A low normal-mode enable also holds the output recessive.

All protections act only on the transmit side. The block has no mode state and no receive path, so the surrounding mode logic and the receiver carry on unchanged whatever a protection does. Each flag is sampled on the block clock, and the inputs are assumed to be already synchronous. Every override takes effect in the same cycle its input rises. Releases are registered.

Top module: `tx_safety_gate`

## Requirements
- R1: While `rst_n` is low, `drive_dom` is 0. After reset release the timer is zero and no latch is set, so `tx_in`=0 with `normal_en`=1 and all flags clear gives `drive_dom`=1.
- R2: `drive_dom` is 0 in any cycle where `normal_en` is 0.
- R3: `drive_dom` is 0 in any cycle where `tx_in` is 1 (recessive).
- R4: If `tx_in` is held at 0 in normal mode, `drive_dom` is 1 for exactly `TIMEOUT_CYC` cycles. After that it stays 0 for as long as `tx_in` stays 0.
- R5: One clock edge with `tx_in`=1 clears the timer, so the next low input again gets a full `TIMEOUT_CYC` dominant window.
- R6: One clock edge with `normal_en`=0 clears the timer.
- R7: `drive_dom` is 0 in any cycle where `thermal_fault` is 1.
- R8: After `thermal_fault` falls, `drive_dom` stays 0 until a clock edge samples `tx_in`=1 with `thermal_fault`=0. A high input seen while the fault is still present does not re-arm.
- R9: `drive_dom` is 0 in any cycle where `mon_low` is 1. `mon_low` takes priority over `mon_high`. Transmit stays disabled until a clock edge samples `mon_high`=1 with `mon_low`=0.
- R10: While `mon_low` and `mon_high` are both 0, the supply-monitor state holds, whether that state is disabled or enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_in | input | 1 | Transmit data level, 0 requests dominant |
| thermal_fault | input | 1 | Junction over-temperature flag |
| mon_low | input | 1 | Supply below the lower monitor level |
| mon_high | input | 1 | Supply at or above the upper monitor level |
| normal_en | input | 1 | Normal mode active |
| drive_dom | output | 1 | 1 drives the bus dominant, 0 releases it |

## Verification
The hardest states to reach are the ones where a latch is still set after its cause has gone. Examples are a thermal fault that dropped while the input was low, or a supply that sits between the two monitor levels after a brown-out. The stimulus builds these with directed sequences. It holds `tx_in` low across the fault's falling edge. It also raises `tx_in` while the fault is still present, to show that this does not re-arm the interlock. It keeps every low stretch shorter than the timeout so the timer cannot hide the latch. An exhaustive sweep of all 32 input combinations taken from a clean reset covers the gating that acts in the same cycle.

// File: rtl/tx_gate_pkg.sv
// Shared types and helpers for the transmit safety gate.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package tx_gate_pkg;

    // One flag per protection that can force the bus recessive.
    typedef struct packed {
        logic timeout;
        logic thermal;
        logic supply;
    } tx_block_t;

    // Counter width needed to hold the values 0..limit.
    function automatic int cnt_width(input int limit);
        int w;
        w = 1;
        while ((1 << w) <= limit) w++;
        return w;
    endfunction

endpackage

// File: rtl/tx_dom_timer.sv
// Stuck-dominant timer. Counts the cycles in which a low input is seen in
// normal mode, saturates at TIMEOUT_CYC and flags a block once saturated.
// Assumes tx_in is synchronous to clk. The block releases as soon as the
// count clears, which happens on a high input or outside normal mode.
module tx_dom_timer
    import tx_gate_pkg::*;
#(
    parameter int TIMEOUT_CYC = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_in,
    input  logic normal_en,
    output logic expired
);
    localparam int CW = cnt_width(TIMEOUT_CYC);
    localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC);

    logic [CW-1:0] cnt;

    // Count low cycles, hold at the limit, clear on a high input or mode exit.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (tx_in || !normal_en)  cnt <= '0;
        else if (cnt != LIM)           cnt <= cnt + CW'(1);
    end

    assign expired = (cnt == LIM);

    p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_en && !tx_in && cnt != LIM) |=> (cnt == $past(cnt) + CW'(1)));
    p_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_en && !tx_in && expired) |=> expired);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in |=> (cnt == '0));
    p_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !normal_en |=> (cnt == '0));
endmodule

// File: rtl/tx_thermal_latch.sv
// Thermal interlock. Blocks transmit while the fault flag is set. After the
// fault clears it keeps blocking until a recessive input is sampled, which
// stops the driver from cycling thermally. Assumes synchronous inputs.
module tx_thermal_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic thermal_fault,
    input  logic tx_in,
    output logic blocked
);
    logic held;

    // Set on a fault, release only on a high input once the fault has gone.
    always_ff @(posedge clk) begin
        if (!rst_n)                       held <= 1'b0;
        else if (thermal_fault)           held <= 1'b1;
        else if (tx_in)                   held <= 1'b0;
    end

    assign blocked = thermal_fault | held;

    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_fault |=> held);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !tx_in) |=> held);
    p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!thermal_fault && tx_in) |=> !held);
endmodule

// File: rtl/tx_supply_hyst.sv
// Supply-monitor hysteresis. The low flag disables transmit at once and
// latches the disable. Only the high flag, with the low flag clear, enables
// it again. Between the two levels the state holds. Assumes the comparator
// flags are already filtered and synchronous.
module tx_supply_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_low,
    input  logic mon_high,
    output logic blocked
);
    logic held;

    // Low level sets the disable and wins over high; high level clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         held <= 1'b0;
        else if (mon_low)   held <= 1'b1;
        else if (mon_high)  held <= 1'b0;
    end

    assign blocked = mon_low | held;

    p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mon_low |=> held);
    p_band_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_low && !mon_high) |=> (held == $past(held)));
endmodule

// File: rtl/tx_safety_gate.sv
// Transmit path safety gate, top level. Combines the stuck-dominant timer,
// the thermal interlock and the supply hysteresis. The bus is driven
// dominant only when the input is low, normal mode is on, reset is released
// and no protection is active. It holds no mode state and does not touch
// reception. Assumes every input is synchronous to clk.
module tx_safety_gate
    import tx_gate_pkg::*;
#(
    parameter int TIMEOUT_CYC = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_in,
    input  logic thermal_fault,
    input  logic mon_low,
    input  logic mon_high,
    input  logic normal_en,
    output logic drive_dom
);
    tx_block_t blk;

    tx_dom_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_in     (tx_in),
        .normal_en (normal_en),
        .expired   (blk.timeout)
    );

    tx_thermal_latch u_thermal (
        .clk           (clk),
        .rst_n         (rst_n),
        .thermal_fault (thermal_fault),
        .tx_in         (tx_in),
        .blocked       (blk.thermal)
    );

    tx_supply_hyst u_supply (
        .clk      (clk),
        .rst_n    (rst_n),
        .mon_low  (mon_low),
        .mon_high (mon_high),
        .blocked  (blk.supply)
    );

    // Final gate: dominant only when requested and nothing objects.
    always_comb begin
        drive_dom = rst_n & normal_en & ~tx_in & ~(|blk);
    end

    p_therm_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        thermal_fault |-> !drive_dom);
    p_supply_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mon_low |-> !drive_dom);
    p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !normal_en |-> !drive_dom);
    p_recessive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in |-> !drive_dom);
endmodule

// File: tb/tx_safety_gate_bench.sv
module tx_safety_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_in = 1'b1, thermal_fault = 1'b0, mon_low = 1'b0, mon_high = 1'b0, normal_en = 1'b0;
    logic drive_dom;
    int total = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_safety_gate #(.TIMEOUT_CYC(LIM)) u_tx_safety_gate (
        .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .thermal_fault(thermal_fault),
        .mon_low(mon_low), .mon_high(mon_high), .normal_en(normal_en),
        .drive_dom(drive_dom)
    );

    task automatic chk(input string req, input logic exp);
        #1;
        total++;
        if (drive_dom !== exp) begin
            fails++;
            $display("FAIL %s: drive_dom actual=%b expected=%b at %0t", req, drive_dom, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_in(input logic t, input logic th, input logic ml, input logic mh, input logic en);
        tx_in = t; thermal_fault = th; mon_low = ml; mon_high = mh; normal_en = en;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        set_in(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1: recessive during reset, clean state afterwards
        @(negedge clk);
        set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R1 in reset", 1'b0);
        tick(); tick();
        rst_n = 1'b1;
        chk("R1 after reset", 1'b1);

        // Exhaustive single-cycle sweep from a clean reset: R2 R3 R7 R9
        for (int v = 0; v < 32; v++) begin
            do_reset();
            set_in(v[0], v[1], v[2], v[3], v[4]);
            chk("R2/R3/R7/R9 sweep", v[4] & ~v[0] & ~v[1] & ~v[2]);
        end

        // R4: dominant window length, then held recessive
        do_reset();
        set_in(1'b1, 1'b0, 1'b0, 1'b0, 1'b1); tick();
        set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < LIM + 4; i++) begin
            chk("R4 timeout window", (i < LIM) ? 1'b1 : 1'b0);
            tick();
        end

        // R5: one high edge re-arms a full window
        tx_in = 1'b1; chk("R5 high input", 1'b0); tick();
        tx_in = 1'b0;
        for (int i = 0; i < LIM + 1; i++) begin
            chk("R5 rearmed window", (i < LIM) ? 1'b1 : 1'b0);
            tick();
        end

        // R6: leaving normal mode clears the timer
        tx_in = 1'b1; tick();
        tx_in = 1'b0;
        for (int i = 0; i < LIM - 1; i++) tick();
        normal_en = 1'b0; chk("R6 mode off", 1'b0); tick();
        normal_en = 1'b1;
        for (int i = 0; i < LIM + 1; i++) begin
            chk("R6 window after mode exit", (i < LIM) ? 1'b1 : 1'b0);
            tick();
        end

        // R7/R8: thermal fault with the input low across its falling edge
        do_reset();
        set_in(1'b0, 1'b1, 1'b0, 1'b0, 1'b1); chk("R7 fault", 1'b0); tick();
        thermal_fault = 1'b0; chk("R8 latched after fault", 1'b0); tick();
        chk("R8 still latched", 1'b0);
        tx_in = 1'b1; chk("R8 high input", 1'b0); tick();
        tx_in = 1'b0; chk("R8 rearmed", 1'b1); tick();

        // R8: high input during the fault does not re-arm
        set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b1); tick();
        set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b1); chk("R8 no rearm during fault", 1'b0); tick();
        tx_in = 1'b1; tick();
        // R8: fault and input high together release on the next clean edge
        set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b1); tick();
        thermal_fault = 1'b0; tick();
        tx_in = 1'b0; chk("R8 release after simultaneous", 1'b1); tick();

        // R9/R10: supply hysteresis
        do_reset();
        set_in(1'b0, 1'b0, 1'b1, 1'b1, 1'b1); chk("R9 low wins over high", 1'b0); tick();
        set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            chk("R10 hold disabled in band", 1'b0);
            tick();
        end
        tx_in = 1'b1; tick();
        tx_in = 1'b0; chk("R9 still disabled before high", 1'b0); tick();
        set_in(1'b1, 1'b0, 1'b0, 1'b1, 1'b1); tick();
        set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b1); chk("R9 enabled after high", 1'b1); tick();
        chk("R10 hold enabled in band", 1'b1); tick();
        mon_low = 1'b1; chk("R9 immediate disable", 1'b0); tick();
        set_in(1'b1, 1'b0, 1'b0, 1'b1, 1'b0); tick();
        set_in(1'b0, 1'b0, 1'b0, 1'b0, 1'b1); chk("R9 enabled after high in mode off", 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule